// File: doc/BRIEF.md
# PCM Highway Receive Slot Extractor

The block watches a serial PCM highway and extracts the data of one channel from it. The highway bit clock and the frame sync arrive as plain inputs and are sampled by the system clock. A data bit is taken at each falling edge of the bit clock, most significant bit first. Slot positions are counted from the frame sync pulse. Software sets four things: a 7-bit slot number, a 3-bit sub-slot delay in whole bit clocks, which of the two serial data inputs to read, and whether the channel carries compressed or linear samples.

A compressed channel yields one 8-bit code word per frame. A linear channel covers two adjacent slots and yields one 16-bit sample per frame. Each result comes with a one-cycle strobe. The block does no companding. Instead it raises a flag that tells the downstream path to skip expansion when the channel is linear. The configuration is latched at every frame start, so a change made part-way through a frame takes effect in the next frame. If the next frame sync arrives before the chosen window has been fully received, that frame produces nothing. This happens when the last slot of a short frame is pushed past the frame end by the sub-slot delay.

Top module: `pcm_rx_slot`

## Requirements
- R1: Bit index 0 is the first bit-clock falling edge at which the frame sync is sampled high after having been sampled low. The index then increases by one on each following falling edge and restarts at every new frame sync.
- R2: In compressed mode (linear_i = 0), the 8 bits at indices 8*slot + offset through 8*slot + offset + 7 are captured MSB first. They are presented as word_o = {8'h00, code}. This holds for every slot 0 to 127.
- R3: In linear mode (linear_i = 1), 16 bits are captured from the same start index. The first slot supplies word_o[15:8] and the second slot supplies word_o[7:0], MSB first.
- R4: The bit offset of 0 to 7 delays the capture window by that many bit clocks.
- R5: port_b_sel_i = 0 reads ser_a_i and port_b_sel_i = 1 reads ser_b_i.
- R6: word_valid_o is high for exactly one system-clock cycle, the cycle after the sampling of the last captured bit. word_o holds its value between strobes.
- R7: If the window has not ended before the next frame sync, that frame gives no strobe. Example: in a 25-bit frame, slot 2 with offset 1 is captured, but slot 2 with offset 2 is not.
- R8: bypass_exp_o equals the linear setting latched at the most recent frame start. It is 0 after reset.
- R9: After reset, word_o is 0 and no strobe appears until a frame sync has been seen.
- R10: The slot, offset, port and mode are latched at the frame start. A change made later in the same frame has no effect on that frame's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pclk_i | input | 1 | Highway bit clock, sampled by clk_i |
| fs_i | input | 1 | Frame sync, marks slot 0 |
| ser_a_i | input | 1 | Serial data input A |
| ser_b_i | input | 1 | Serial data input B |
| slot_i | input | 7 | Assigned slot number |
| bit_offset_i | input | 3 | Sub-slot delay in bit clocks |
| port_b_sel_i | input | 1 | 1 selects ser_b_i |
| linear_i | input | 1 | 1 selects linear (two-slot) samples |
| word_o | output | 16 | Captured code word or linear sample |
| word_valid_o | output | 1 | One-cycle strobe for word_o |
| bypass_exp_o | output | 1 | Tells the downstream path to skip expansion |

## Verification
On every cycle, the assertions check the following:
- bit-clock edges are never back to back, and the bit index steps by one and restarts at zero on each frame sync;
- the strobe lasts exactly one cycle and follows a bit-clock edge;
- word_o changes only together with the strobe;
- compressed results have a zero upper byte.

Only the bench scenarios can show the rest: that the correct bits end up in the word for each slot, offset, port and mode, that a window which overruns the frame is dropped, and that a configuration change in mid-frame is deferred.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned BYTE_SH   = $clog2(BYTE_BITS);

  typedef enum logic {
    CODE_COMP = 1'b0,
    CODE_LIN  = 1'b1
  } code_mode_e;
endpackage

// File: rtl/pclk_edge.sv
module pclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pclk_i,
  input  logic fs_i,
  output logic tick_o,
  output logic frame_start_o
);
  logic pclk_q, fs_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q    <= 1'b0;
      fs_prev_q <= 1'b0;
    end else begin
      pclk_q <= pclk_i;
      if (tick_o) fs_prev_q <= fs_i;
    end
  end

  assign tick_o        = pclk_q & ~pclk_i;
  assign frame_start_o = tick_o & fs_i & ~fs_prev_q;

  p_tick_spaced_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int unsigned IDX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             frame_start_i,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic             active_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q;
  logic             in_frame_q;

  always_comb begin
    if (frame_start_i)         cur_idx_o = '0;
    else if (idx_q == IDX_MAX) cur_idx_o = IDX_MAX;
    else                       cur_idx_o = idx_q + 1'b1;
  end

  assign active_o = frame_start_i | in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (tick_i && active_o) begin
      idx_q      <= cur_idx_o;
      in_frame_q <= 1'b1;
    end
  end

  p_idx_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (idx_q == '0));
  p_idx_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !frame_start_i && in_frame_q && idx_q != IDX_MAX)
      |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/slot_capture.sv
module slot_capture
  import pcm_rx_pkg::*;
#(
  parameter int unsigned SLOT_W = 7,
  parameter int unsigned OFFS_W = 3,
  parameter int unsigned IDX_W  = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 frame_start_i,
  input  logic                 active_i,
  input  logic [IDX_W-1:0]     cur_idx_i,
  input  logic                 ser_a_i,
  input  logic                 ser_b_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [OFFS_W-1:0]    offs_i,
  input  logic                 psel_i,
  input  logic                 linear_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 valid_o,
  output logic                 bypass_o
);
  logic [SLOT_W-1:0] slot_q, slot_e;
  logic [OFFS_W-1:0] offs_q, offs_e;
  logic              psel_q, psel_e;
  code_mode_e        mode_q, mode_e;

  logic [IDX_W-1:0]     start_idx, last_idx;
  logic                 in_win, bit_sel;
  logic [WORD_BITS-2:0] sr_q;

  // Configuration seen at the frame-start edge applies immediately.
  always_comb begin
    if (frame_start_i) begin
      slot_e = slot_i;
      offs_e = offs_i;
      psel_e = psel_i;
      mode_e = code_mode_e'(linear_i);
    end else begin
      slot_e = slot_q;
      offs_e = offs_q;
      psel_e = psel_q;
      mode_e = mode_q;
    end
  end

  always_comb begin
    start_idx = (IDX_W'(slot_e) << BYTE_SH) + IDX_W'(offs_e);
    last_idx  = start_idx + ((mode_e == CODE_LIN) ? IDX_W'(WORD_BITS - 1)
                                                  : IDX_W'(BYTE_BITS - 1));
    in_win    = active_i && (cur_idx_i >= start_idx) && (cur_idx_i <= last_idx);
    bit_sel   = psel_e ? ser_b_i : ser_a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      offs_q <= '0;
      psel_q <= 1'b0;
      mode_q <= CODE_COMP;
    end else if (frame_start_i) begin
      slot_q <= slot_i;
      offs_q <= offs_i;
      psel_q <= psel_i;
      mode_q <= code_mode_e'(linear_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i && in_win) begin
        sr_q <= {sr_q[WORD_BITS-3:0], bit_sel};
        if (cur_idx_i == last_idx) begin
          valid_o <= 1'b1;
          if (mode_e == CODE_LIN)
            word_o <= {sr_q, bit_sel};
          else
            word_o <= {{(WORD_BITS-BYTE_BITS){1'b0}}, sr_q[BYTE_BITS-2:0], bit_sel};
        end
      end
    end
  end

  assign bypass_o = (mode_q == CODE_LIN);

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_valid_after_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));
  p_word_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> valid_o);
  p_comp_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !bypass_o) |-> (word_o[WORD_BITS-1:BYTE_BITS] == '0));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_rx_pkg::*;
#(
  parameter int unsigned SLOT_W = 7,
  parameter int unsigned OFFS_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pclk_i,
  input  logic                 fs_i,
  input  logic                 ser_a_i,
  input  logic                 ser_b_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [OFFS_W-1:0]    bit_offset_i,
  input  logic                 port_b_sel_i,
  input  logic                 linear_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_valid_o,
  output logic                 bypass_exp_o
);
  localparam int unsigned IDX_W = SLOT_W + OFFS_W + 2;

  logic             tick, frame_start, active;
  logic [IDX_W-1:0] cur_idx;

  pclk_edge u_edge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pclk_i        (pclk_i),
    .fs_i          (fs_i),
    .tick_o        (tick),
    .frame_start_o (frame_start)
  );

  bit_timer #(.IDX_W(IDX_W)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .frame_start_i (frame_start),
    .cur_idx_o     (cur_idx),
    .active_o      (active)
  );

  slot_capture #(.SLOT_W(SLOT_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_cap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .frame_start_i (frame_start),
    .active_i      (active),
    .cur_idx_i     (cur_idx),
    .ser_a_i       (ser_a_i),
    .ser_b_i       (ser_b_i),
    .slot_i        (slot_i),
    .offs_i        (bit_offset_i),
    .psel_i        (port_b_sel_i),
    .linear_i      (linear_i),
    .word_o        (word_o),
    .valid_o       (word_valid_o),
    .bypass_o      (bypass_exp_o)
  );

  p_no_strobe_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(active));
endmodule

// File: tb/pcm_rx_slot_test.sv
module pcm_rx_slot_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pclk = 1'b0, fs = 1'b0, ser_a = 1'b0, ser_b = 1'b0;
  logic [6:0]  slot = '0;
  logic [2:0]  offs = '0;
  logic        psel = 1'b0, lin = 1'b0;
  logic [15:0] word;
  logic        valid, bypass;

  int          checks = 0, errors = 0, cyc = 0, exp_cyc = -1;
  logic [15:0] exp_word = '0, held = '0;
  logic        exp_byp = 1'b0;
  string       cur_req = "R9";
  logic        ba [0:1279];
  logic        bb [0:1279];

  always #10 clk = ~clk;

  pcm_rx_slot uut (
    .clk_i(clk), .rst_ni(rst_ni), .pclk_i(pclk), .fs_i(fs),
    .ser_a_i(ser_a), .ser_b_i(ser_b), .slot_i(slot), .bit_offset_i(offs),
    .port_b_sel_i(psel), .linear_i(lin),
    .word_o(word), .word_valid_o(valid), .bypass_exp_o(bypass)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // One system clock; reference comparison every cycle.
  task automatic step();
    logic ev;
    @(negedge clk);
    cyc++;
    ev = (cyc == exp_cyc);
    check({cur_req, " R6 strobe"}, {15'd0, valid}, {15'd0, ev});
    if (ev) begin
      check({cur_req, " word"}, word, exp_word);
      check("R8 bypass", {15'd0, bypass}, {15'd0, exp_byp});
      held = exp_word;
    end else begin
      check("R6 hold", word, held);
    end
  endtask

  task automatic frame(input int nbits, input int s, input int o, input int p, input int l,
                       input int s2, input int o2, input int p2, input int l2,
                       input string req);
    int st, ln;
    logic ok;
    logic [15:0] w;
    cur_req = req;
    slot = 7'(s); offs = 3'(o); psel = p[0]; lin = l[0];
    for (int k = 0; k < nbits; k++) begin
      ba[k] = 1'($urandom);
      bb[k] = 1'($urandom);
    end
    st = 8 * s + o;
    ln = l ? 16 : 8;
    ok = (st + ln <= nbits);
    w = '0;
    if (ok)
      for (int j = 0; j < ln; j++) w = {w[14:0], p ? bb[st+j] : ba[st+j]};
    for (int k = 0; k < nbits; k++) begin
      if (k == 2) begin
        slot = 7'(s2); offs = 3'(o2); psel = p2[0]; lin = l2[0];
      end
      pclk = 1'b1; fs = (k == 0); ser_a = ba[k]; ser_b = bb[k];
      step(); step();
      pclk = 1'b0;
      if (ok && k == st + ln - 1) begin
        exp_cyc = cyc + 1;
        exp_word = w;
        exp_byp = l[0];
      end
      step(); step();
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset word", word, 16'h0000);
    check("R9 reset strobe", {15'd0, valid}, 16'd0);
    check("R8 reset bypass", {15'd0, bypass}, 16'd0);
    rst_ni = 1'b1;
    // R9: bit clock running without frame sync gives nothing
    cur_req = "R9";
    for (int k = 0; k < 40; k++) begin
      pclk = 1'b1; ser_a = 1'($urandom); step(); step();
      pclk = 1'b0; step(); step();
    end
    frame(32, 1, 0, 0, 0, 1, 0, 0, 0, "R1 R2 slot1");
    frame(32, 0, 0, 0, 0, 0, 0, 0, 0, "R1 R2 slot0");
    frame(48, 2, 5, 0, 0, 2, 5, 0, 0, "R4 offset5");
    frame(48, 3, 7, 0, 0, 3, 7, 0, 0, "R4 offset7");
    frame(16, 0, 0, 1, 0, 0, 0, 1, 0, "R5 portB");
    frame(16, 0, 3, 0, 0, 0, 3, 0, 0, "R5 portA");
    frame(40, 1, 3, 1, 1, 1, 3, 1, 1, "R3 R8 linear");
    frame(24, 0, 0, 0, 1, 0, 0, 0, 1, "R3 linear slot0");
    frame(40, 0, 1, 0, 0, 3, 7, 1, 1, "R10 mid-frame change");
    frame(40, 1, 0, 1, 1, 0, 0, 0, 0, "R10 linear kept");
    frame(25, 2, 1, 0, 0, 2, 1, 0, 0, "R7 fits");
    frame(25, 2, 2, 0, 0, 2, 2, 0, 0, "R7 overrun");
    frame(24, 1, 0, 0, 1, 1, 0, 0, 1, "R7 linear fits");
    frame(24, 2, 0, 0, 1, 2, 0, 0, 1, "R7 linear overrun");
    frame(1031, 127, 7, 1, 0, 127, 7, 1, 0, "R2 slot127");
    frame(16, 0, 0, 0, 0, 0, 0, 0, 0, "R8 back to comp");
    check("R8 bypass after comp frame", {15'd0, bypass}, 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule